// File: doc/BRIEF.md
# Restart Boot-Set State Capture

This block captures the start-up behaviour of a small four-stage ring-oscillator entropy source. It does not collect a long random stream. It forces the oscillator through a series of restarts. Before each restart it holds the oscillator enable low for a programmed number of clock cycles, so that every run begins from the same stopped state. It then releases the enable and records a fixed number of consecutive 4-bit state samples taken on the system clock. The oscillator runs unrelated to that clock, so every bit of the state passes through a two-flop synchronizer before it is stored.

The default build takes 8 restarts of 128 samples each, so one boot contributes 512 bits. When the whole boot set is in the buffer, the block pulses `done_o` and streams the symbols out over a valid/ready interface. The order is boot by boot, oldest sample first within each boot, and `m_last_o` marks the final symbol of every boot. While `m_valid_o` is high and `m_ready_i` is low, the symbol and its last flag stay frozen. A symbol is consumed only in a cycle where both are high. The stream has no gaps: valid stays high from the `done_o` cycle until the final handshake. The downstream side therefore sets the pace alone.

Top module: `boot_capture_top`

## Requirements
- R1: During and right after reset, `osc_en_o`, `busy_o`, `done_o` and `m_valid_o` are all low.
- R2: A `start_i` pulse seen while the block is idle (not busy, not streaming) raises `busy_o` in the next cycle, with `osc_en_o` still low.
- R3: One capture holds `osc_en_o` high in exactly BOOTS separate windows of exactly SAMPLES cycles each. Each window is preceded by a low period of the programmed hold length, counted from the cycle `busy_o` rises or from the end of the previous window.
- R4: Sample j (0-based) of boot b is the value on `osc_state_i` at the rising edge that ends the j-th cycle of the b-th enable window. It is taken through the two-flop synchronizer. Values seen while the enable is low are never stored.
- R5: `busy_o` stays high until the last sample is written. `done_o` is a one-cycle pulse in the first cycle `busy_o` is low, and `m_valid_o` rises in that same cycle.
- R6: The readout yields BOOTS*SAMPLES symbols, boot 0 first and oldest sample first within each boot. `m_last_o` is high exactly on the symbol with in-boot index SAMPLES-1.
- R7: While `m_valid_o` is high and `m_ready_i` is low, `m_data_o` and `m_last_o` hold their values and the read position does not move.
- R8: `start_i` is ignored while busy or while streaming. After the final handshake `m_valid_o` drops, the block is idle, and a new start is accepted.
- R9: The hold length is latched from `hold_cycles_i` when a start is accepted. Later changes to that input do not affect the capture in progress.
- R10: A hold length of 0 behaves as a hold of 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a boot-set capture (taken only when idle) |
| hold_cycles_i | input | HOLD_W | Number of cycles the enable stays low before each run |
| osc_state_i | input | SYM_W | Asynchronous stage outputs of the oscillator |
| osc_en_o | output | 1 | Oscillator enable; low forces the stopped initial state |
| busy_o | output | 1 | High from accepted start until the last sample is stored |
| done_o | output | 1 | One-cycle pulse when the buffer is full |
| m_valid_o | output | 1 | Stream symbol valid |
| m_ready_i | input | 1 | Stream consumer ready |
| m_data_o | output | SYM_W | Stream symbol (one 4-bit state sample) |
| m_last_o | output | 1 | Final symbol of a boot |

## Verification
The bench builds the block with 16 samples per boot, 4 boots and a 6-bit hold field. A full capture and readout therefore takes about a hundred cycles. That keeps room for several captures with different hold lengths (0, 1, 3 and 9) and three ready patterns, from always-ready to a heavy stall. The bench runs a cycle-exact oscillator model whose output depends on both the window number and the cycle within the window. Any slip in the synchronizer delay, the enable window length or the boot order therefore shows up as a wrong symbol. Start pulses are injected both mid-capture and mid-stream, and the hold input is changed after a start, to exercise the ignore and latch rules.

// File: rtl/bootcap_pkg.sv
`timescale 1ns/1ps
package bootcap_pkg;

  typedef enum logic [2:0] {
    CAP_IDLE   = 3'd0,
    CAP_HOLD   = 3'd1,
    CAP_RUN    = 3'd2,
    CAP_DRAIN  = 3'd3,
    CAP_STREAM = 3'd4
  } cap_state_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bootcap_sync.sv
`timescale 1ns/1ps
module bootcap_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/bootcap_ctrl.sv
`timescale 1ns/1ps
module bootcap_ctrl
  import bootcap_pkg::*;
#(
  parameter int SAMPLES = 128,
  parameter int BOOTS   = 8,
  parameter int HOLD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  input  logic              buf_full_i,
  input  logic              rd_done_i,
  output logic              run_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              stream_o
);

  localparam int SCNT_W = cnt_width(SAMPLES);
  localparam int BCNT_W = cnt_width(BOOTS);
  localparam logic [SCNT_W-1:0] RUN_LAST  = SCNT_W'(SAMPLES - 1);
  localparam logic [BCNT_W-1:0] BOOT_LAST = BCNT_W'(BOOTS - 1);

  cap_state_e        state_q;
  logic [HOLD_W-1:0] hold_q;
  logic [HOLD_W-1:0] hold_cnt_q;
  logic [SCNT_W-1:0] run_cnt_q;
  logic [BCNT_W-1:0] boot_cnt_q;
  logic [HOLD_W-1:0] hold_lim;
  logic              hold_end;
  logic              run_end;

  // A zero hold would give no stopped cycle at all, so it is raised to one
  assign hold_lim = (hold_q == '0) ? HOLD_W'(1) : hold_q;
  assign hold_end = (hold_cnt_q == (hold_lim - HOLD_W'(1)));
  assign run_end  = (run_cnt_q == RUN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= CAP_IDLE;
      hold_q     <= '0;
      hold_cnt_q <= '0;
      run_cnt_q  <= '0;
      boot_cnt_q <= '0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        CAP_IDLE: begin
          if (start_i) begin
            state_q    <= CAP_HOLD;
            hold_q     <= hold_cycles_i;
            hold_cnt_q <= '0;
            boot_cnt_q <= '0;
          end
        end
        CAP_HOLD: begin
          hold_cnt_q <= hold_cnt_q + HOLD_W'(1);
          if (hold_end) begin
            state_q   <= CAP_RUN;
            run_cnt_q <= '0;
          end
        end
        CAP_RUN: begin
          run_cnt_q <= run_cnt_q + SCNT_W'(1);
          if (run_end) begin
            if (boot_cnt_q == BOOT_LAST) begin
              state_q <= CAP_DRAIN;
            end else begin
              state_q    <= CAP_HOLD;
              hold_cnt_q <= '0;
              boot_cnt_q <= boot_cnt_q + BCNT_W'(1);
            end
          end
        end
        CAP_DRAIN: begin
          // samples still travel through the synchronizer after the last run
          if (buf_full_i) begin
            state_q <= CAP_STREAM;
            done_o  <= 1'b1;
          end
        end
        CAP_STREAM: begin
          if (rd_done_i) state_q <= CAP_IDLE;
        end
        default: state_q <= CAP_IDLE;
      endcase
    end
  end

  assign run_o    = (state_q == CAP_RUN);
  assign busy_o   = (state_q == CAP_HOLD) || (state_q == CAP_RUN) || (state_q == CAP_DRAIN);
  assign stream_o = (state_q == CAP_STREAM);

endmodule

// File: rtl/bootcap_store.sv
`timescale 1ns/1ps
module bootcap_store
  import bootcap_pkg::*;
#(
  parameter int SYM_W   = 4,
  parameter int SAMPLES = 128,
  parameter int BOOTS   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [SYM_W-1:0] wr_data_i,
  output logic             full_o,
  input  logic             stream_i,
  input  logic             m_ready_i,
  output logic             m_valid_o,
  output logic [SYM_W-1:0] m_data_o,
  output logic             m_last_o,
  output logic             rd_done_o
);

  localparam int TOTAL  = SAMPLES * BOOTS;
  localparam int ADDR_W = cnt_width(TOTAL);
  localparam int SCNT_W = cnt_width(SAMPLES);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(TOTAL - 1);
  localparam logic [SCNT_W-1:0] SYM_LAST  = SCNT_W'(SAMPLES - 1);

  logic [SYM_W-1:0]  mem_q [TOTAL];
  logic [ADDR_W-1:0] wr_addr_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [SCNT_W-1:0] rd_sym_q;
  logic              rd_fire;
  logic              wr_last;

  assign wr_last = (wr_addr_q == ADDR_LAST);
  assign full_o  = wr_en_i && wr_last;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_addr_q] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr_q <= '0;
    end else if (wr_en_i) begin
      wr_addr_q <= wr_last ? '0 : wr_addr_q + ADDR_W'(1);
    end
  end

  assign m_valid_o = stream_i;
  assign rd_fire   = stream_i && m_ready_i;
  assign m_data_o  = mem_q[rd_addr_q];
  assign m_last_o  = stream_i && (rd_sym_q == SYM_LAST);
  assign rd_done_o = rd_fire && (rd_addr_q == ADDR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      rd_sym_q  <= '0;
    end else if (rd_fire) begin
      rd_addr_q <= (rd_addr_q == ADDR_LAST) ? '0 : rd_addr_q + ADDR_W'(1);
      rd_sym_q  <= (rd_sym_q == SYM_LAST) ? '0 : rd_sym_q + SCNT_W'(1);
    end
  end

endmodule

// File: rtl/boot_capture_top.sv
`timescale 1ns/1ps
module boot_capture_top #(
  parameter int SYM_W       = 4,
  parameter int SAMPLES     = 128,
  parameter int BOOTS       = 8,
  parameter int HOLD_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  input  logic [SYM_W-1:0]  osc_state_i,
  output logic              osc_en_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [SYM_W-1:0]  m_data_o,
  output logic              m_last_o
);

  localparam int LANE_W = SYM_W + 1;

  logic              run;
  logic              stream;
  logic              buf_full;
  logic              rd_done;
  logic [LANE_W-1:0] lane_d;
  logic [LANE_W-1:0] lane_q;

  bootcap_ctrl #(
    .SAMPLES (SAMPLES),
    .BOOTS   (BOOTS),
    .HOLD_W  (HOLD_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .hold_cycles_i (hold_cycles_i),
    .buf_full_i    (buf_full),
    .rd_done_i     (rd_done),
    .run_o         (run),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .stream_o      (stream)
  );

  assign osc_en_o = run;

  // The run flag rides the same delay line as the state bits, so a word is
  // written exactly when it was sampled inside an enable window.
  assign lane_d = {run, osc_state_i};

  bootcap_sync #(
    .WIDTH  (LANE_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (lane_d),
    .q_o   (lane_q)
  );

  bootcap_store #(
    .SYM_W   (SYM_W),
    .SAMPLES (SAMPLES),
    .BOOTS   (BOOTS)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (lane_q[SYM_W]),
    .wr_data_i (lane_q[SYM_W-1:0]),
    .full_o    (buf_full),
    .stream_i  (stream),
    .m_ready_i (m_ready_i),
    .m_valid_o (m_valid_o),
    .m_data_o  (m_data_o),
    .m_last_o  (m_last_o),
    .rd_done_o (rd_done)
  );

endmodule

// File: rtl/bootcap_checker.sv
`timescale 1ns/1ps
module bootcap_checker #(
  parameter int SYM_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             osc_en_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             m_valid_o,
  input logic             m_ready_i,
  input logic [SYM_W-1:0] m_data_o,
  input logic             m_last_o
);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !m_valid_o) |=> (busy_o && !osc_en_o));

  assert_en_inside_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en_o |-> busy_o);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_handover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && m_valid_o));

  assert_busy_fall_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_stall_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o) && $stable(m_last_o)));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_valid_o && busy_o));

endmodule

bind boot_capture_top bootcap_checker #(.SYM_W(SYM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .osc_en_o  (osc_en_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .m_valid_o (m_valid_o),
  .m_ready_i (m_ready_i),
  .m_data_o  (m_data_o),
  .m_last_o  (m_last_o)
);

// File: tb/tb_boot_capture_top.sv
`timescale 1ns/1ps
module tb_boot_capture_top;

  localparam int SYM_W   = 4;
  localparam int SAMPLES = 16;
  localparam int BOOTS   = 4;
  localparam int HOLD_W  = 6;
  localparam int TOTAL   = SAMPLES * BOOTS;
  localparam int WIN_MAX = 64;
  localparam logic [SYM_W-1:0] STOPPED = 4'hA;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [HOLD_W-1:0] hold_cycles_i = '0;
  logic [SYM_W-1:0]  osc_state_i = STOPPED;
  logic              osc_en_o;
  logic              busy_o;
  logic              done_o;
  logic              m_valid_o;
  logic              m_ready_i = 1'b0;
  logic [SYM_W-1:0]  m_data_o;
  logic              m_last_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  boot_capture_top #(
    .SYM_W   (SYM_W),
    .SAMPLES (SAMPLES),
    .BOOTS   (BOOTS),
    .HOLD_W  (HOLD_W)
  ) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .hold_cycles_i (hold_cycles_i),
    .osc_state_i   (osc_state_i),
    .osc_en_o      (osc_en_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .m_valid_o     (m_valid_o),
    .m_ready_i     (m_ready_i),
    .m_data_o      (m_data_o),
    .m_last_o      (m_last_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Oscillator model: value depends on window number and cycle in window
  function automatic logic [SYM_W-1:0] fosc(input int j, input int w);
    return SYM_W'(j * 3 + w * 5 + (j >> 3)) ^ SYM_W'(w * 9);
  endfunction

  int win_n   = 0;
  int en_cnt  = 0;
  int low_run = 0;
  bit en_prev = 1'b0;
  int en_len  [WIN_MAX];
  int low_len [WIN_MAX];

  always @(negedge clk) begin
    if (osc_en_o) begin
      if (!en_prev) begin
        low_len[win_n % WIN_MAX] = low_run;
        en_cnt = 0;
      end
      osc_state_i = fosc(en_cnt, win_n);
      en_cnt = en_cnt + 1;
      low_run = 0;
    end else begin
      if (en_prev) begin
        en_len[win_n % WIN_MAX] = en_cnt;
        win_n = win_n + 1;
      end
      osc_state_i = STOPPED;
      if (busy_o) low_run = low_run + 1;
      else        low_run = 0;
    end
    en_prev = osc_en_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic bit ready_pat(input int mode, input int n);
    case (mode)
      0:       return 1'b1;
      1:       return (n % 3) != 1;
      default: return (n % 4) == 0;
    endcase
  endfunction

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    chk(osc_en_o == 1'b0, "R1", osc_en_o, 0, "osc_en in reset");
    chk(busy_o == 1'b0, "R1", busy_o, 0, "busy in reset");
    rst_n = 1'b1;
    tick();
    chk(done_o == 1'b0, "R1", done_o, 0, "done after reset");
    chk(m_valid_o == 1'b0, "R1", m_valid_o, 0, "valid after reset");
  endtask

  // One capture plus full readout
  task automatic t_capture(input int hold, input int rmode, input bit poke_busy,
                           input bit poke_stream, input bit change_hold);
    int base;
    int exp_hold;
    int k;
    int idx;
    int n;
    bit got_done;
    bit rdy;
    bit poked;
    base = win_n;
    exp_hold = (hold == 0) ? 1 : hold;
    hold_cycles_i = HOLD_W'(hold);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2", busy_o, 1, "busy after start");
    chk(osc_en_o == 1'b0, "R2", osc_en_o, 0, "enable low after start");
    if (change_hold) hold_cycles_i = HOLD_W'(hold + 7);
    got_done = 1'b0;
    for (k = 0; k < 2000 && !got_done; k++) begin
      start_i = poke_busy && (k == 20);
      tick();
      if (done_o) got_done = 1'b1;
    end
    start_i = 1'b0;
    chk(got_done, "R5", got_done, 1, "done pulse seen");
    chk(!busy_o && m_valid_o, "R5", {busy_o, m_valid_o}, 1, "done cycle busy/valid");
    chk(win_n - base == BOOTS, "R3", win_n - base, BOOTS, "enable windows (R8 start ignored)");
    for (int b = 0; b < BOOTS; b++) begin
      chk(en_len[(base + b) % WIN_MAX] == SAMPLES, "R3",
          en_len[(base + b) % WIN_MAX], SAMPLES, "window length");
      chk(low_len[(base + b) % WIN_MAX] == exp_hold, change_hold ? "R9" : (hold == 0 ? "R10" : "R3"),
          low_len[(base + b) % WIN_MAX], exp_hold, "hold length");
    end
    idx = 0;
    n = 0;
    poked = 1'b0;
    while (idx < TOTAL && n < 4000) begin
      if (poked) chk(busy_o == 1'b0 && osc_en_o == 1'b0, "R8", busy_o, 0, "start during stream");
      chk(m_valid_o == 1'b1, "R6", m_valid_o, 1, "valid during stream");
      chk(m_data_o == fosc(idx % SAMPLES, base + idx / SAMPLES), (n > 0 && !rdy) ? "R7" : "R4",
          m_data_o, fosc(idx % SAMPLES, base + idx / SAMPLES), "symbol value");
      chk(m_last_o == ((idx % SAMPLES) == SAMPLES - 1), "R6", m_last_o,
          (idx % SAMPLES) == SAMPLES - 1, "last flag");
      rdy = ready_pat(rmode, n);
      m_ready_i = rdy;
      poked = poke_stream && (idx == 5) && !rdy;
      start_i = poked;
      tick();
      if (rdy) idx++;
      n++;
    end
    m_ready_i = 1'b0;
    start_i = 1'b0;
    chk(idx == TOTAL, "R6", idx, TOTAL, "symbols read");
    chk(m_valid_o == 1'b0 && busy_o == 1'b0, "R8", {m_valid_o, busy_o}, 0, "idle after readout");
    tick();
    chk(osc_en_o == 1'b0 && busy_o == 1'b0, "R8", busy_o, 0, "no capture started");
  endtask

  initial begin
    t_reset();
    t_capture(3, 0, 1'b0, 1'b0, 1'b0);
    t_capture(0, 1, 1'b1, 1'b0, 1'b0);
    t_capture(9, 2, 1'b0, 1'b1, 1'b1);
    t_capture(1, 1, 1'b1, 1'b1, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait (cyc >= 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule